// File: doc/BRIEF.md
# Dual-Line Peripheral Interrupt Aggregator

This block gathers thirty single-cycle event pulses from a bus controller's core logic into sticky flags and presents them to the system as two level-sensitive interrupt outputs. Each source has its own enable bit and its own route bit. The route bit picks which of the two outputs the source drives. Each output also has a master enable. Software clears a flag by writing a one to its bit. A flag latches even while its source is disabled, so a disabled source can still be polled.

The source numbering is fixed. Bits 0 to 3 are the first receive queue's events: new entry, watermark, full, and entry lost. Bits 4 to 7 are the same four events for the second receive queue. Bit 25 reports that the node has left the bus, and bit 29 reports an access to a reserved address. Register access uses a plain 32-bit bus with an address, a write strobe and write data. Read data is combinational.

The block has no sequencing state machine. Its behaviour is held in four registers, each with a single named update rule: flag, source enable, route and line enable. The registered output stage is the only pipeline stage.

Top module: `dual_line_irq_agg`

## Requirements
- R1: After reset the flag, source-enable, route and line-enable registers all read zero, and both interrupt outputs are low.
- R2: An event pulse on source bit i sets flag i at the next clock edge. The flag stays set until it is cleared, whatever the enable bit of that source.
- R3: A write to offset 0x00 clears every flag whose write-data bit is 1 and leaves every flag whose write-data bit is 0 unchanged.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Route bit i set to 0 sends source i to output line 0, and set to 1 sends it to output line 1.
- R6: A flagged source drives no output while its source-enable bit is 0.
- R7: Line-enable bit 0 gates output line 0 and bit 1 gates output line 1. A line whose bit is 0 stays low.
- R8: The outputs are registered. A line rises one clock edge after the edge that sets the flag driving it.
- R9: Bits 31 and 30 of the flag, source-enable and route registers read as zero and ignore writes. Bits 31 to 2 of the line-enable register read as zero.
- R10: The registers sit at these offsets: flags 0x00, source enable 0x04, route 0x08, line enable 0x0C. Reads from any other offset return zero, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| evt_pulse_i | input | 30 | Single-cycle event pulses, one per source |
| irq_line0_o | output | 1 | Interrupt output line 0 |
| irq_line1_o | output | 1 | Interrupt output line 1 |

## Verification
An event pulse and a clearing write to the flag register can land on the same flag in the same clock cycle. The bench provokes this by driving an event on source 5 in the same cycle as a write of bit 5 to offset 0x00. It then reads the flag register back and requires bit 5 to still be set, with the line output still high. A second case sets and clears different bits in the same cycle, and here the clear must take effect only on its own bits.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NUM_SRC   = 30;
    localparam int NUM_LINES = 2;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] OFF_FLAG  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SRCEN = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ROUTE = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_LINEN = 8'h0C;

    typedef enum logic [2:0] {
        SEL_FLAG,
        SEL_SRCEN,
        SEL_ROUTE,
        SEL_LINEN,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            OFF_FLAG:  s = SEL_FLAG;
            OFF_SRCEN: s = SEL_SRCEN;
            OFF_ROUTE: s = SEL_ROUTE;
            OFF_LINEN: s = SEL_LINEN;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NSRC = irq_agg_pkg::NUM_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] flags
);
    // Sticky flags: a new event overrides a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | evt;
        end
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int NSRC   = irq_agg_pkg::NUM_SRC,
    parameter int NLINES = irq_agg_pkg::NUM_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_srcen,
    input  logic              wr_route,
    input  logic              wr_linen,
    input  logic [NSRC-1:0]   wdata_src,
    input  logic [NLINES-1:0] wdata_line,
    output logic [NSRC-1:0]   src_en,
    output logic [NSRC-1:0]   route,
    output logic [NLINES-1:0] line_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en  <= '0;
            route   <= '0;
            line_en <= '0;
        end else begin
            if (wr_srcen) src_en  <= wdata_src;
            if (wr_route) route   <= wdata_src;
            if (wr_linen) line_en <= wdata_line;
        end
    end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
    parameter int NSRC   = irq_agg_pkg::NUM_SRC,
    parameter int NLINES = irq_agg_pkg::NUM_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   flags,
    input  logic [NSRC-1:0]   src_en,
    input  logic [NSRC-1:0]   route,
    input  logic [NLINES-1:0] line_en,
    output logic [NLINES-1:0] irq
);
    logic [NSRC-1:0] live;
    assign live = flags & src_en;

    for (genvar n = 0; n < NLINES; n++) begin : g_line
        localparam bit TO_ONE = (n == 1);
        logic [NSRC-1:0] member;
        assign member = TO_ONE ? route : ~route;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq[n] <= 1'b0;
            end else begin
                irq[n] <= line_en[n] & (|(live & member));
            end
        end
    end
endmodule

// File: rtl/dual_line_irq_agg.sv
module dual_line_irq_agg
    import irq_agg_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NSRC-1:0]   evt_pulse_i,
    output logic              irq_line0_o,
    output logic              irq_line1_o
);
    localparam int PAD_SRC  = DATA_W - NSRC;
    localparam int PAD_LINE = DATA_W - NUM_LINES;

    reg_sel_e sel;
    logic [NSRC-1:0]      flag_q, src_en_q, route_q, clr_mask;
    logic [NUM_LINES-1:0] line_en_q, irq_q;
    logic wr_srcen, wr_route, wr_linen;

    assign sel = decode_addr(bus_addr_i);

    always_comb begin
        clr_mask = '0;
        wr_srcen = 1'b0;
        wr_route = 1'b0;
        wr_linen = 1'b0;
        if (bus_we_i) begin
            unique case (sel)
                SEL_FLAG:  clr_mask = bus_wdata_i[NSRC-1:0];
                SEL_SRCEN: wr_srcen = 1'b1;
                SEL_ROUTE: wr_route = 1'b1;
                SEL_LINEN: wr_linen = 1'b1;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_FLAG:  bus_rdata_o = {{PAD_SRC{1'b0}}, flag_q};
            SEL_SRCEN: bus_rdata_o = {{PAD_SRC{1'b0}}, src_en_q};
            SEL_ROUTE: bus_rdata_o = {{PAD_SRC{1'b0}}, route_q};
            SEL_LINEN: bus_rdata_o = {{PAD_LINE{1'b0}}, line_en_q};
            default:   bus_rdata_o = '0;
        endcase
    end

    irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt(evt_pulse_i),
        .clr_mask(clr_mask), .flags(flag_q)
    );

    irq_cfg_regs #(.NSRC(NSRC), .NLINES(NUM_LINES)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_srcen(wr_srcen), .wr_route(wr_route), .wr_linen(wr_linen),
        .wdata_src(bus_wdata_i[NSRC-1:0]),
        .wdata_line(bus_wdata_i[NUM_LINES-1:0]),
        .src_en(src_en_q), .route(route_q), .line_en(line_en_q)
    );

    irq_line_router #(.NSRC(NSRC), .NLINES(NUM_LINES)) u_route (
        .clk(clk), .rst_n(rst_n), .flags(flag_q), .src_en(src_en_q),
        .route(route_q), .line_en(line_en_q), .irq(irq_q)
    );

    assign irq_line0_o = irq_q[0];
    assign irq_line1_o = irq_q[1];
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_SRC-1:0] evt,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] src_en,
    input logic [NUM_LINES-1:0] line_en,
    input logic              irq0,
    input logic              irq1
);
    a_r2_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    a_r3_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFF_FLAG) |=>
        ((flags & $past(wdata[NUM_SRC-1:0] & ~evt)) == '0));

    a_r6_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == '0) |=> (!irq0 && !irq1));

    a_r7_line0_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en[0] |=> !irq0);

    a_r7_line1_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en[1] |=> !irq1);

    a_r9_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

bind dual_line_irq_agg irq_agg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse_i), .we(bus_we_i),
    .addr(bus_addr_i), .wdata(bus_wdata_i), .rdata(bus_rdata_o),
    .flags(flag_q), .src_en(src_en_q), .line_en(line_en_q),
    .irq0(irq_line0_o), .irq1(irq_line1_o)
);

// File: tb/dual_line_irq_agg_bench.sv
module dual_line_irq_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [29:0] evt = '0;
    logic        irq0, irq1;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_line_irq_agg u_dual_line_irq_agg (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_pulse_i(evt),
        .irq_line0_o(irq0), .irq_line1_o(irq1)
    );

    typedef struct packed {
        logic [29:0] ev;
        logic [29:0] en;
        logic [29:0] rt;
        logic [1:0]  le;
        logic        e0;
        logic        e1;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{30'h1,                        30'h1,       30'h0,       2'b11, 1'b1, 1'b0},
        '{30'h1 << 25,                  30'h1 << 25, 30'h1 << 25, 2'b11, 1'b0, 1'b1},
        '{30'h8,                        30'h0,       30'h0,       2'b11, 1'b0, 1'b0},
        '{(30'h1 << 29) | 30'h10,       (30'h1 << 29) | 30'h10, 30'h10, 2'b01, 1'b1, 1'b0},
        '{30'h80,                       30'h80,      30'h80,      2'b10, 1'b0, 1'b1},
        '{30'h3000,                     30'h2000,    30'h1000,    2'b11, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input logic [29:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        logic [31:0] r;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        rd(8'h00, r); check("R1 flags", r, 32'h0);
        rd(8'h04, r); check("R1 srcen", r, 32'h0);
        rd(8'h08, r); check("R1 route", r, 32'h0);
        rd(8'h0C, r); check("R1 linen", r, 32'h0);
        check("R1 irq", {30'h0, irq1, irq0}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            wr(8'h00, 32'hFFFF_FFFF);
            wr(8'h04, {2'b0, VEC[i].en});
            wr(8'h08, {2'b0, VEC[i].rt});
            wr(8'h0C, {30'h0, VEC[i].le});
            pulse(VEC[i].ev);
            @(negedge clk);
            rd(8'h00, r); check("R2 flag latch", r, {2'b0, VEC[i].ev});
            check("R5/R6/R7 lines", {30'h0, irq1, irq0}, {30'h0, VEC[i].e1, VEC[i].e0});
        end

        // R8 timing
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'h1);
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h3);
        @(negedge clk);
        pulse(30'h1);
        rd(8'h00, r); check("R8 flag at edge", r, 32'h1);
        check("R8 line not yet", {31'h0, irq0}, 32'h0);
        @(negedge clk);
        check("R8 line one edge later", {31'h0, irq0}, 32'h1);

        // R3 write-one-to-clear
        wr(8'h00, 32'hFFFF_FFFF);
        pulse(30'h6);
        wr(8'h00, 32'h2);
        rd(8'h00, r); check("R3 clear bit1 only", r, 32'h4);
        wr(8'h00, 32'h0);
        rd(8'h00, r); check("R3 zero write keeps", r, 32'h4);

        // R4 event beats clear
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'h20);
        evt = 30'h20;
        wr(8'h00, 32'h20);
        evt = '0;
        rd(8'h00, r); check("R4 event wins", r, 32'h20);
        @(negedge clk);
        check("R4 line stays high", {31'h0, irq0}, 32'h1);
        // R4 clear of other bits in same cycle
        evt = 30'h1;
        wr(8'h00, 32'h20);
        evt = '0;
        rd(8'h00, r); check("R4 distinct bits", r, 32'h1);

        // R9 reserved bits
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, r); check("R9 srcen reserved", r, 32'h3FFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, r); check("R9 route reserved", r, 32'h3FFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, r); check("R9 linen reserved", r, 32'h3);

        // R10 unmapped offsets
        wr(8'h10, 32'h0);
        wr(8'h05, 32'h0);
        rd(8'h10, r); check("R10 unmapped read", r, 32'h0);
        rd(8'h04, r); check("R10 unmapped write srcen", r, 32'h3FFF_FFFF);
        rd(8'h0C, r); check("R10 unmapped write linen", r, 32'h3);
        rd(8'h00, r); check("R10 unmapped write flags", r, 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule